// File: doc/BRIEF.md
# Programmable Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock by modulo-2 long division held in a shift register. Each frame opens with a start pulse, which loads the generator polynomial, its degree and the operating mode, and clears the division register. Message bits then arrive most significant first, one on each cycle that the valid strobe is high. A marker flags the final bit.

In generate mode every accepted bit is passed to the serial output one cycle later. After the final bit the block feeds as many zero bits into the divider as the degree of the generator. It then shifts the finished remainder out, most significant bit first, and pulses done. In check mode the received bits, including the trailing check bits, are divided with no extra zeros. Done then pulses with error set when the remainder is not all zeros. The running remainder is always visible on a parallel output.

Top module: `serial_crc`

## Requirements
- R1: While reset is held and after it is released, dout_valid_o, done_o and error_o are low and rem_o is zero.
- R2: A start_i pulse clears rem_o to zero from the next cycle and latches poly_i, deg_i and check_mode_i (1 = check, 0 = generate). poly_i bit k is the coefficient of x^k, and the leading x^deg term is implied. Later changes to these three inputs have no effect until the next start. A start during a frame abandons that frame.
- R3: A bit is accepted on each cycle with din_valid_i high, most significant first. In generate mode each accepted bit appears on dout_o with dout_valid_o high in the next cycle.
- R4: On a cycle with din_valid_i low during the message, rem_o stays unchanged, nothing is output and din_last_i is ignored.
- R5: In generate mode, the cycle after the last bit is followed by deg cycles of zero feeding with dout_valid_o low. Then come deg consecutive cycles that carry the remainder, most significant bit first. The data inputs are ignored throughout.
- R6: With generator 11011, message 01011101010110 yields check bits 1111 and message 10111101001101 yields 0001.
- R7: In generate mode done_o is high for exactly one cycle, the cycle after the last remainder bit, with error_o low.
- R8: In check mode nothing is output serially. done_o is high for one cycle, the cycle after the bit marked last is accepted, and error_o is high then exactly when the final remainder is non-zero.
- R9: rem_o always equals the remainder of the bits fed so far, augmentation zeros included, divided by the latched generator.
- R10: error_o is never high unless done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame: clear register, latch settings |
| check_mode_i | input | 1 | 1 = check received frame, 0 = generate |
| poly_i | input | MAX_DEG | Generator coefficients below the leading term |
| deg_i | input | $clog2(MAX_DEG+1) | Generator degree, 1 to MAX_DEG |
| din_i | input | 1 | Serial message bit |
| din_valid_i | input | 1 | din_i carries a bit this cycle |
| din_last_i | input | 1 | The bit this cycle is the final one |
| dout_o | output | 1 | Serial transmit bit |
| dout_valid_o | output | 1 | dout_o carries a bit this cycle |
| rem_o | output | MAX_DEG | Running remainder, low deg bits used |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| error_o | output | 1 | Non-zero remainder in check mode, valid with done_o |

## Verification
The assertions take for granted that deg_i lies between 1 and MAX_DEG whenever start_i is pulsed. They also take for granted that a frame is only considered finished by din_last_i on a cycle that also has din_valid_i. The stimulus programs degrees 1, 3, 4 and 16 only. It raises din_last_i together with a low valid during stalls, so that path is exercised without ending a frame. It pulses start_i between frames, and once in mid-frame on purpose.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RUN  = 3'd1,
        ST_AUG  = 3'd2,
        ST_EMIT = 3'd3,
        ST_FIN  = 3'd4
    } crc_state_e;

    typedef enum logic {
        MODE_GEN   = 1'b0,
        MODE_CHECK = 1'b1
    } crc_mode_e;

endpackage

// File: rtl/crc_step.sv
// One modulo-2 division step: shift in one bit, subtract the generator
// when the bit leaving the top of the active register is set.
module crc_step #(
    parameter  int MAX_DEG = 16,
    localparam int DW      = $clog2(MAX_DEG + 1)
) (
    input  logic [MAX_DEG-1:0] crc_i,
    input  logic [MAX_DEG-1:0] taps_i,
    input  logic [DW-1:0]      deg_i,
    input  logic               bit_i,
    output logic [MAX_DEG-1:0] crc_o
);

    logic lead;

    // leading bit of the partial dividend sits at position deg-1
    always_comb begin
        lead = 1'b0;
        for (int k = 0; k < MAX_DEG; k++) begin
            if (DW'(k) + DW'(1) == deg_i) begin
                lead = crc_i[k];
            end
        end
    end

    for (genvar i = 0; i < MAX_DEG; i++) begin : g_bit
        logic shin;
        if (i == 0) begin : g_lsb
            assign shin = bit_i;
        end else begin : g_up
            assign shin = crc_i[i-1];
        end
        assign crc_o[i] = (DW'(i) < deg_i) & (shin ^ (lead & taps_i[i]));
    end

endmodule

// File: rtl/crc_bitsel.sv
// Picks remainder bit (deg-1-idx) so the remainder leaves MSB first.
module crc_bitsel #(
    parameter  int MAX_DEG = 16,
    localparam int DW      = $clog2(MAX_DEG + 1)
) (
    input  logic [MAX_DEG-1:0] crc_i,
    input  logic [DW-1:0]      deg_i,
    input  logic [DW-1:0]      idx_i,
    output logic               bit_o
);

    always_comb begin
        bit_o = 1'b0;
        for (int k = 0; k < MAX_DEG; k++) begin
            if (DW'(k) + idx_i + DW'(1) == deg_i) begin
                bit_o = crc_i[k];
            end
        end
    end

endmodule

// File: rtl/serial_crc.sv
module serial_crc
    import crc_pkg::*;
#(
    parameter  int MAX_DEG = 16,
    localparam int DW      = $clog2(MAX_DEG + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               check_mode_i,
    input  logic [MAX_DEG-1:0] poly_i,
    input  logic [DW-1:0]      deg_i,
    input  logic               din_i,
    input  logic               din_valid_i,
    input  logic               din_last_i,
    output logic               dout_o,
    output logic               dout_valid_o,
    output logic [MAX_DEG-1:0] rem_o,
    output logic               done_o,
    output logic               error_o
);

    typedef struct packed {
        crc_state_e         state;
        crc_mode_e          mode;
        logic [MAX_DEG-1:0] taps;
        logic [DW-1:0]      deg;
        logic [MAX_DEG-1:0] crc;
        logic [DW-1:0]      cnt;
        logic               dout;
        logic               dvld;
        logic               done;
        logic               err;
    } crc_regs_t;

    crc_regs_t r_d, r_q;

    logic               step_bit;
    logic [MAX_DEG-1:0] step_crc;
    logic               emit_bit;
    logic               cnt_last;

    // message bits during the frame, zeros during augmentation
    assign step_bit = (r_q.state == ST_RUN) ? din_i : 1'b0;
    assign cnt_last = (r_q.cnt == r_q.deg - DW'(1));

    crc_step #(.MAX_DEG(MAX_DEG)) i_step (
        .crc_i  (r_q.crc),
        .taps_i (r_q.taps),
        .deg_i  (r_q.deg),
        .bit_i  (step_bit),
        .crc_o  (step_crc)
    );

    crc_bitsel #(.MAX_DEG(MAX_DEG)) i_bitsel (
        .crc_i (r_q.crc),
        .deg_i (r_q.deg),
        .idx_i (r_q.cnt),
        .bit_o (emit_bit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.dvld = 1'b0;
        r_d.dout = 1'b0;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;

        unique case (r_q.state)
            ST_RUN: begin
                if (din_valid_i) begin
                    r_d.crc = step_crc;
                    if (r_q.mode == MODE_GEN) begin
                        r_d.dvld = 1'b1;
                        r_d.dout = din_i;
                    end
                    if (din_last_i) begin
                        r_d.cnt = '0;
                        if (r_q.mode == MODE_CHECK) begin
                            r_d.done  = 1'b1;
                            r_d.err   = |step_crc;
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.state = ST_AUG;
                        end
                    end
                end
            end
            ST_AUG: begin
                r_d.crc = step_crc;
                r_d.cnt = r_q.cnt + DW'(1);
                if (cnt_last) begin
                    r_d.cnt   = '0;
                    r_d.state = ST_EMIT;
                end
            end
            ST_EMIT: begin
                r_d.dvld = 1'b1;
                r_d.dout = emit_bit;
                r_d.cnt  = r_q.cnt + DW'(1);
                if (cnt_last) begin
                    r_d.cnt   = '0;
                    r_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        if (start_i) begin
            r_d.state = ST_RUN;
            r_d.mode  = crc_mode_e'(check_mode_i);
            r_d.taps  = poly_i;
            r_d.deg   = deg_i;
            r_d.crc   = '0;
            r_d.cnt   = '0;
            r_d.dvld  = 1'b0;
            r_d.dout  = 1'b0;
            r_d.done  = 1'b0;
            r_d.err   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout_o       = r_q.dout;
    assign dout_valid_o = r_q.dvld;
    assign rem_o        = r_q.crc;
    assign done_o       = r_q.done;
    assign error_o      = r_q.err;

    // R7/R8: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: error only alongside done
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    // R8: no serial output from a frame latched in check mode
    a_r8_silent_check: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid_o |-> (r_q.mode == MODE_GEN));

    // R4: a stall leaves the remainder untouched
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && !din_valid_i && !start_i) |=> $stable(rem_o));

    // R2: start clears the division register
    a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (rem_o == '0));

    // R5: phase counter stays inside the programmed degree
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_AUG || r_q.state == ST_EMIT) |-> (r_q.cnt < r_q.deg));

    // R5: the augmentation phase produces no serial output
    a_r5_aug_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_AUG && !start_i) |=> !dout_valid_o);

endmodule

// File: tb/test_serial_crc.sv
`timescale 1ns/1ps
module test_serial_crc;

    localparam int MAX_DEG = 16;
    localparam int DW      = $clog2(MAX_DEG + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic               check_mode_i = 1'b0;
    logic [MAX_DEG-1:0] poly_i = '0;
    logic [DW-1:0]      deg_i = '0;
    logic               din_i = 1'b0;
    logic               din_valid_i = 1'b0;
    logic               din_last_i = 1'b0;
    logic               dout_o;
    logic               dout_valid_o;
    logic [MAX_DEG-1:0] rem_o;
    logic               done_o;
    logic               error_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit fed[$];
    int m_poly;
    int m_deg;
    bit seen_err;

    bit m1[$], m2[$], m3[$], m4[$], m5[$];
    bit tx1[$], tx2[$], tx3[$], tx4[$], tx5[$], junk[$], bad[$];

    always #10 clk = ~clk;

    serial_crc #(.MAX_DEG(MAX_DEG)) i_serial_crc (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .check_mode_i (check_mode_i),
        .poly_i       (poly_i),
        .deg_i        (deg_i),
        .din_i        (din_i),
        .din_valid_i  (din_valid_i),
        .din_last_i   (din_last_i),
        .dout_o       (dout_o),
        .dout_valid_o (dout_valid_o),
        .rem_o        (rem_o),
        .done_o       (done_o),
        .error_o      (error_o)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // plain long division over GF(2) on a bit list
    function automatic int ref_rem(input bit d[$], input int poly, input int deg);
        bit w[$];
        int r = 0;
        int first;
        w = d;
        for (int i = 0; i + deg < w.size(); i++) begin
            if (w[i]) begin
                for (int j = 0; j <= deg; j++) w[i+j] ^= poly[deg-j];
            end
        end
        first = (w.size() > deg) ? w.size() - deg : 0;
        for (int k = first; k < w.size(); k++) r = (r << 1) | int'(w[k]);
        return r;
    endfunction

    function automatic void mk(output bit q[$], input logic [63:0] v, input int n);
        q.delete();
        for (int i = n - 1; i >= 0; i--) q.push_back(v[i]);
    endfunction

    // drive one cycle, then compare outputs after the edge
    task automatic tick(input bit st, input bit vld, input bit d, input bit lst,
                        input bit feed, input bit fbit,
                        input bit e_v, input bit e_d, input bit e_done, input bit e_chk,
                        input string tag);
        int exp_rem;
        start_i     = st;
        din_valid_i = vld;
        din_i       = d;
        din_last_i  = lst;
        if (st) fed.delete();
        if (feed) fed.push_back(fbit);
        @(negedge clk);
        exp_rem = ref_rem(fed, m_poly, m_deg);
        check(tag, "dout_valid", int'(dout_valid_o), int'(e_v));
        if (e_v) check(tag, "dout", int'(dout_o), int'(e_d));
        check(tag, "done", int'(done_o), int'(e_done));
        check("R10", "error", int'(error_o), int'(e_done && e_chk && exp_rem != 0));
        check("R9", "rem", int'(rem_o), exp_rem);
        if (e_done) seen_err = error_o;
    endtask

    task automatic frame(input bit chk, input int poly, input int deg, input bit msg[$],
                         input int stall, input int stop_at, output bit tx[$],
                         input string tag);
        int r;
        bit lst;
        tx.delete();
        seen_err = 1'b0;
        m_poly = poly;
        m_deg = deg;
        poly_i = poly[MAX_DEG-1:0];
        deg_i = DW'(deg);
        check_mode_i = chk;
        tick(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R2: settings changed after start must be ignored
        poly_i = ~poly_i;
        deg_i = DW'(3);
        check_mode_i = ~chk;
        for (int i = 0; i < msg.size(); i++) begin
            if (stall > 0 && (i % stall) == stall - 1) begin
                tick(0, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R4");
            end
            lst = (i == msg.size() - 1);
            tick(0, 1, msg[i], lst, 1, msg[i], !chk, msg[i], chk && lst, chk && lst,
                 chk ? "R8" : "R3");
            if (!chk) tx.push_back(msg[i]);
            if (i + 1 == stop_at) return;
        end
        if (!chk) begin
            for (int k = 0; k < deg; k++) tick(0, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R5");
            r = ref_rem(fed, poly, deg);
            for (int k = 0; k < deg; k++) begin
                tick(0, 1, 1, 1, 0, 0, 1, r[deg-1-k], 0, 0, "R5");
                tx.push_back(r[deg-1-k]);
            end
            tick(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");
        end
        tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    function automatic int tail(input bit q[$], input int n);
        int v = 0;
        for (int k = q.size() - n; k < q.size(); k++) v = (v << 1) | int'(q[k]);
        return v;
    endfunction

    initial begin
        m_poly = 3;
        m_deg = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "dout_valid", int'(dout_valid_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "error", int'(error_o), 0);
        check("R1", "rem", int'(rem_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rem after release", int'(rem_o), 0);
        check("R1", "done after release", int'(done_o), 0);

        // R6: worked examples with generator 11011
        mk(m1, 64'b01011101010110, 14);
        frame(0, 'b11011, 4, m1, 0, 99, tx1, "R6");
        check("R6", "check bits ex1", tail(tx1, 4), 'b1111);
        check("R6", "length ex1", tx1.size(), 18);
        mk(m2, 64'b10111101001101, 14);
        frame(0, 'b11011, 4, m2, 3, 99, tx2, "R6");
        check("R6", "check bits ex2", tail(tx2, 4), 'b0001);

        // R8: transmitted streams check clean, corrupted one flags
        frame(1, 'b11011, 4, tx1, 0, 99, junk, "R8");
        check("R8", "clean ex1", int'(seen_err), 0);
        frame(1, 'b11011, 4, tx2, 4, 99, junk, "R8");
        check("R8", "clean ex2", int'(seen_err), 0);
        bad = tx1;
        bad[5] = ~bad[5];
        frame(1, 'b11011, 4, bad, 2, 99, junk, "R8");
        check("R8", "single flip", int'(seen_err), 1);

        // R2: abandon a frame mid-way, then restart cleanly
        mk(m3, 64'hB5, 8);
        frame(0, 'b1011, 3, m3, 0, 5, junk, "R2");
        frame(0, 'b1011, 3, m3, 2, 99, tx3, "R2");
        frame(1, 'b1011, 3, tx3, 0, 99, junk, "R2");
        check("R2", "restart clean", int'(seen_err), 0);

        // R9: full-degree generator
        mk(m4, 64'hA5C391F07E, 40);
        frame(0, 'h18005, 16, m4, 0, 99, tx4, "R9");
        frame(1, 'h18005, 16, tx4, 5, 99, junk, "R9");
        check("R9", "deg16 clean", int'(seen_err), 0);
        bad = tx4;
        bad[50] = ~bad[50];
        frame(1, 'h18005, 16, bad, 0, 99, junk, "R9");
        check("R9", "deg16 flip", int'(seen_err), 1);

        // R5: degree-1 generator (parity)
        mk(m5, 64'h5B, 7);
        frame(0, 'b11, 1, m5, 2, 99, tx5, "R5");
        check("R5", "parity bit", tail(tx5, 1), 1);
        frame(1, 'b11, 1, tx5, 0, 99, junk, "R5");
        check("R5", "parity clean", int'(seen_err), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule